// File: doc/BRIEF.md
# Composite Bus Reference-Data Inserter

This block forms the 8-bit composite video output bus of a genlocking digitizer. Outside the horizontal sync tip it passes each raw sample through a digital offset clamp. The clamp moves the measured blanking level to a code that depends on the format. Inside the sync tip it puts a reference burst of 4-bit nibbles in place of the samples. The burst carries a field-identity nibble and then the 24-bit subcarrier frequency and 24-bit subcarrier phase words. Downstream decoders and encoders use these to regenerate the colour carrier.

Samples arrive as a valid/ready stream, one bus slot per beat. A reference nibble takes one beat. The output is a one-stage registered valid/ready stream. A beat is accepted when `s_valid` and `s_ready` are both high. `s_ready` is high whenever the output register is empty or is being drained in the same cycle. While `m_valid` is high and `m_ready` is low, the output beat is held unchanged and no new beat is taken. `s_tip` travels with each beat and marks it as lying inside the sync tip. The control and measurement pins are plain levels, sampled with each accepted beat.

The frequency and phase words are captured into holding registers on the first tip beat of a line, together with the field identity. All reference nibbles of one line therefore form a coherent set, even when the measured words change in the middle of the burst.

Top module: `cbi_top`

## Requirements
- R1: An accepted beat appears on `m_data` with `m_valid` high on the following cycle. `s_ready` equals `!m_valid || m_ready`. While `m_valid && !m_ready`, `m_valid` and `m_data` stay unchanged. Reset clears `m_valid`.
- R2: With `clamp_en` high, a non-tip, non-reference beat outputs raw − `blank_lvl` + 3Ch when `fmt_pal` is low, or raw − `blank_lvl` + 40h when `fmt_pal` is high.
- R3: The clamped value of R2 saturates at 00h below and at FFh above.
- R4: With `clamp_en` low, non-reference beats output the raw sample unchanged.
- R5: With `clamp_en` high, a tip beat that is not a reference slot outputs `tip_lvl` for NTSC or `tip_lvl` + 4 for PAL. With `tip_lvl` = 3h this gives 03h and 07h.
- R6: The first 13 tip beats of a line are reference slots, in this order: the field nibble, then frequency bits 23:20 down to 3:0, then phase bits 23:20 down to 3:0. Each nibble is on bits 3:0 and bits 7:4 are zero. A tip run that ends and starts again restarts at the field nibble.
- R7: Field nibble, NTSC (`fmt_pal` low): bit 3 = 1, bit 2 = 0, bits 1:0 = `field_cnt[1:0]`. Field nibble, PAL (`fmt_pal` high): bits 2:0 = `field_cnt`, bit 3 = !`line_swing`, so an inverted (225°) line gives 0.
- R8: The frequency, phase and field values sent in one burst are those present on the first tip beat. Later changes do not show until the next tip run.
- R9: With `ref_off` high, no reference slots are sent, and tip beats follow R4/R5.
- R10: With `force_low` high and `pll_locked` low, every non-reference beat outputs 00h. Reference slots are still sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock (2x pixel rate) |
| rst_n | input | 1 | Synchronous active-low reset |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted when high with s_valid |
| s_data | input | 8 | Raw digitized sample |
| s_tip | input | 1 | Beat lies inside the horizontal sync tip |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | 8 | Composite bus value |
| blank_lvl | input | 8 | Measured back-porch level |
| sc_freq | input | 24 | Measured subcarrier frequency word |
| sc_phase | input | 24 | Measured subcarrier phase word |
| field_cnt | input | 3 | Field counter (0-based) |
| fmt_pal | input | 1 | High selects PAL, low NTSC |
| line_swing | input | 1 | PAL line with inverted V (225° burst) |
| clamp_en | input | 1 | Digital clamp enable |
| ref_off | input | 1 | Suppress reference nibbles |
| force_low | input | 1 | Zero non-reference data while unlocked |
| pll_locked | input | 1 | Line loop lock indication |
| tip_lvl | input | 4 | Sync-tip output code for NTSC |

## Verification
Capture of the reference words and output back-pressure can fall in the same cycle. So can capture and a change of the measured words. The bench stalls `m_ready` on a repeating pattern while a tip run begins, and changes `sc_freq`/`sc_phase` a few beats into a burst. A behavioural model keeps its own snapshot of the words at the first tip beat and checks every transferred beat in order. A lost, duplicated or re-captured nibble therefore shows up as a mismatch. A tip run that is cut short and then restarted checks that the sequence starts again at the field nibble.

// File: rtl/cbi_pkg.sv
package cbi_pkg;
  localparam logic [7:0] NTSC_BLANK_CODE = 8'h3C;
  localparam logic [7:0] PAL_BLANK_CODE  = 8'h40;
  localparam int         PAL_TIP_LIFT    = 4;

  // Field-identity nibble: bit3 carries burst sense, bits2:0 the field count
  function automatic logic [3:0] field_nibble(input logic pal, input logic swing,
                                              input logic [2:0] fld);
    return pal ? {~swing, fld} : {1'b1, 1'b0, fld[1:0]};
  endfunction
endpackage

// File: rtl/cbi_clamp.sv
module cbi_clamp
  import cbi_pkg::*;
#(
  parameter int DW = 8,
  parameter int NW = 4
) (
  input  logic [DW-1:0] raw,
  input  logic [DW-1:0] blank,
  input  logic          pal,
  input  logic          en,
  input  logic          tip,
  input  logic [NW-1:0] tip_lvl,
  output logic [DW-1:0] lvl_out
);
  localparam logic [DW-1:0] BASE_N = DW'(NTSC_BLANK_CODE);
  localparam logic [DW-1:0] BASE_P = DW'(PAL_BLANK_CODE);
  localparam logic [DW-1:0] LIFT   = DW'(PAL_TIP_LIFT);
  localparam logic signed [DW+1:0] TOP = $signed({2'b00, {DW{1'b1}}});

  logic [DW-1:0]          base;
  logic signed [DW+1:0]   sum;
  logic [DW-1:0]          sat;
  logic [DW-1:0]          tip_code;

  always_comb begin
    base = pal ? BASE_P : BASE_N;
    sum  = $signed({2'b00, raw}) - $signed({2'b00, blank}) + $signed({2'b00, base});
    if (sum < 0)        sat = '0;
    else if (sum > TOP) sat = '1;
    else                sat = sum[DW-1:0];
    tip_code = DW'(tip_lvl) + (pal ? LIFT : '0);
    if (!en)      lvl_out = raw;
    else if (tip) lvl_out = tip_code;
    else          lvl_out = sat;
  end
endmodule

// File: rtl/cbi_refseq.sv
module cbi_refseq
  import cbi_pkg::*;
#(
  parameter int NW = 4,
  parameter int WW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          tip,
  input  logic          pal,
  input  logic          swing,
  input  logic [2:0]    field,
  input  logic [WW-1:0] freq,
  input  logic [WW-1:0] phase,
  output logic          ref_slot,
  output logic [NW-1:0] ref_nib
);
  localparam int NN    = WW / NW;
  localparam int SLOTS = 1 + 2 * NN;
  localparam int IW    = $clog2(SLOTS + 1);

  logic          in_tip_q;
  logic [IW-1:0] idx_q;
  logic [WW-1:0] freq_q, phase_q;
  logic [NW-1:0] fid_q;

  logic          first;
  logic [IW-1:0] idx;
  logic [WW-1:0] fw, pw;
  logic [NW-1:0] fid_live, fid;
  int            sh;

  always_comb begin
    first    = tip && !in_tip_q;
    idx      = first ? '0 : idx_q;
    fid_live = NW'(field_nibble(pal, swing, field));
    fw       = first ? freq  : freq_q;
    pw       = first ? phase : phase_q;
    fid      = first ? fid_live : fid_q;
    ref_slot = tip && (int'(idx) < SLOTS);
    sh       = 0;
    ref_nib  = '0;
    if (idx == '0) begin
      ref_nib = fid;
    end else if (int'(idx) <= NN) begin
      sh      = NW * (NN - int'(idx));
      ref_nib = NW'(fw >> sh);
    end else begin
      sh      = NW * (2 * NN - int'(idx));
      ref_nib = NW'(pw >> sh);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_tip_q <= 1'b0;
      idx_q    <= '0;
      freq_q   <= '0;
      phase_q  <= '0;
      fid_q    <= '0;
    end else if (adv) begin
      in_tip_q <= tip;
      if (first) begin
        freq_q  <= freq;
        phase_q <= phase;
        fid_q   <= fid_live;
        idx_q   <= IW'(1);
      end else if (tip && (int'(idx_q) < SLOTS)) begin
        idx_q <= idx_q + IW'(1);
      end
    end
  end

  // R8: once a burst is under way the held words must not move
  a_r8_hold_coherent: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && tip && in_tip_q) |=> ($stable(freq_q) && $stable(phase_q) && $stable(fid_q)));
endmodule

// File: rtl/cbi_top.sv
module cbi_top #(
  parameter int DW = 8,
  parameter int NW = 4,
  parameter int WW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  input  logic          s_tip,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_data,
  input  logic [DW-1:0] blank_lvl,
  input  logic [WW-1:0] sc_freq,
  input  logic [WW-1:0] sc_phase,
  input  logic [2:0]    field_cnt,
  input  logic          fmt_pal,
  input  logic          line_swing,
  input  logic          clamp_en,
  input  logic          ref_off,
  input  logic          force_low,
  input  logic          pll_locked,
  input  logic [NW-1:0] tip_lvl
);
  logic          accept;
  logic          ref_slot;
  logic [NW-1:0] ref_nib;
  logic [DW-1:0] clamp_out;
  logic [DW-1:0] nxt;

  assign s_ready = !m_valid || m_ready;
  assign accept  = s_valid && s_ready;

  cbi_refseq #(.NW(NW), .WW(WW)) u_seq (
    .clk(clk), .rst_n(rst_n), .adv(accept), .tip(s_tip), .pal(fmt_pal),
    .swing(line_swing), .field(field_cnt), .freq(sc_freq), .phase(sc_phase),
    .ref_slot(ref_slot), .ref_nib(ref_nib)
  );

  cbi_clamp #(.DW(DW), .NW(NW)) u_clamp (
    .raw(s_data), .blank(blank_lvl), .pal(fmt_pal), .en(clamp_en),
    .tip(s_tip), .tip_lvl(tip_lvl), .lvl_out(clamp_out)
  );

  always_comb begin
    if (ref_slot && !ref_off)           nxt = {{(DW-NW){1'b0}}, ref_nib};
    else if (force_low && !pll_locked)  nxt = '0;
    else                                nxt = clamp_out;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (accept) begin
      m_valid <= 1'b1;
      m_data  <= nxt;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  // R1: a stalled output beat is held
  a_r1_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
  // R1: an accepted beat is presented next cycle
  a_r1_accept_out: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> m_valid);
  // R6: reference slots occupy only the low nibble
  a_r6_low_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ref_slot && !ref_off) |=> (m_data[DW-1:NW] == '0));
  // R10: unlocked with force-low gives zero outside reference slots
  a_r10_force_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && force_low && !pll_locked && !(ref_slot && !ref_off)) |=> (m_data == '0));
endmodule

// File: tb/test_cbi_top.sv
module test_cbi_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0, s_ready, s_tip = 1'b0, m_valid, m_ready = 1'b1;
  logic [7:0] s_data = '0, m_data, blank_lvl = 8'h20;
  logic [23:0] sc_freq = 24'hA1B2C3, sc_phase = 24'h4D5E6F;
  logic [2:0] field_cnt = 3'd2;
  logic fmt_pal = 0, line_swing = 0, clamp_en = 1, ref_off = 0, force_low = 0, pll_locked = 1;
  logic [3:0] tip_lvl = 4'h3;

  int checks = 0, fails = 0;
  bit stall_en = 0, done = 0;
  int cyc = 0;

  logic [7:0] exq[$];
  string      tagq[$];
  bit         mdl_in_tip = 0;
  int         mdl_slot = 0;
  logic [23:0] mdl_f, mdl_p;
  logic [3:0]  mdl_fid;

  always #(CLK_P/2) clk = ~clk;

  cbi_top i_cbi_top (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_tip(s_tip), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .blank_lvl(blank_lvl), .sc_freq(sc_freq), .sc_phase(sc_phase), .field_cnt(field_cnt),
    .fmt_pal(fmt_pal), .line_swing(line_swing), .clamp_en(clamp_en), .ref_off(ref_off),
    .force_low(force_low), .pll_locked(pll_locked), .tip_lvl(tip_lvl)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // Behavioural model of one accepted beat
  task automatic model_beat(input logic [7:0] raw, input bit tip);
    int v; logic [7:0] e; string t;
    if (tip && !mdl_in_tip) begin
      mdl_f = sc_freq; mdl_p = sc_phase; mdl_slot = 0;
      mdl_fid = fmt_pal ? {~line_swing, field_cnt} : {2'b10, field_cnt[1:0]};
    end
    if (tip && mdl_slot < 13 && !ref_off) begin
      if (mdl_slot == 0) begin e = {4'h0, mdl_fid}; t = "R7 field nibble"; end
      else if (mdl_slot <= 6) begin e = {4'h0, 4'((mdl_f >> (4*(6-mdl_slot))) & 24'hF)}; t = "R6/R8 freq nibble"; end
      else begin e = {4'h0, 4'((mdl_p >> (4*(12-mdl_slot))) & 24'hF)}; t = "R6/R8 phase nibble"; end
    end else if (force_low && !pll_locked) begin e = 8'h00; t = "R10 forced zero"; end
    else if (!clamp_en) begin e = raw; t = "R4 passthrough"; end
    else if (tip) begin e = 8'(int'(tip_lvl) + (fmt_pal ? 4 : 0)); t = ref_off ? "R9 tip code" : "R5 tip code"; end
    else begin
      v = int'(raw) - int'(blank_lvl) + (fmt_pal ? 'h40 : 'h3C);
      if (v < 0) begin e = 8'h00; t = "R3 low saturation"; end
      else if (v > 255) begin e = 8'hFF; t = "R3 high saturation"; end
      else begin e = 8'(v); t = "R2 clamp"; end
    end
    if (tip) mdl_slot++;
    mdl_in_tip = tip;
    exq.push_back(e); tagq.push_back(t);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (m_valid && m_ready) begin
        if (exq.size() == 0) check("R1 unexpected beat", m_data, 8'hxx);
        else check(tagq.pop_front(), m_data, exq.pop_front());
      end
      if (s_valid && s_ready) model_beat(s_data, s_tip);
    end
  end

  always @(posedge clk) begin
    cyc++;
    #1 m_ready = stall_en ? ((cyc % 3) != 0) : 1'b1;
  end

  task automatic send(input logic [7:0] d, input bit t);
    s_valid = 1'b1; s_data = d; s_tip = t;
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    @(posedge clk); #1;
    s_valid = 1'b0;
  endtask

  task automatic tip_run(input int n);
    for (int i = 0; i < n; i++) send(8'h05, 1'b1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 60000);
    checks++; fails++;
    $display("FAIL R1 watchdog actual=hung expected=complete");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset m_valid", {7'b0, m_valid}, 8'h00);
    check("R1 reset s_ready", {7'b0, s_ready}, 8'h01);
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R2/R3 NTSC pixels
    send(8'h20, 0); send(8'h80, 0); send(8'hFF, 0); send(8'h00, 0);
    blank_lvl = 8'h60; send(8'h00, 0); blank_lvl = 8'h20;
    // R5/R6/R7 NTSC tip line
    tip_run(16); send(8'h40, 0);
    // R6 short tip then restart
    tip_run(5); send(8'h30, 0); tip_run(14);
    // PAL: R2, R5, R7 with inverted line
    fmt_pal = 1; line_swing = 1; field_cnt = 3'd5;
    send(8'h20, 0); send(8'hF0, 0); tip_run(15);
    line_swing = 0; field_cnt = 3'd7; tip_run(14); send(8'h10, 0);
    // R8 words change mid-burst while output stalls
    stall_en = 1;
    fmt_pal = 0; field_cnt = 3'd3;
    send(8'h22, 0);
    for (int i = 0; i < 15; i++) begin
      if (i == 4) begin sc_freq = 24'h123456; sc_phase = 24'h789ABC; end
      send(8'h05, 1);
    end
    send(8'h50, 0);
    tip_run(14); send(8'h60, 0);
    stall_en = 0;
    // R9 reference suppressed
    ref_off = 1; tip_run(6); send(8'h21, 0); ref_off = 0;
    // R10 forced zero while unlocked
    force_low = 1; pll_locked = 0;
    send(8'h99, 0); tip_run(15); send(8'h77, 0);
    force_low = 0; pll_locked = 1;
    // R4 clamp disabled
    clamp_en = 0;
    send(8'h5A, 0); send(8'hFF, 0); tip_run(14);
    clamp_en = 1; tip_lvl = 4'hC; fmt_pal = 1; tip_run(14);
    repeat (10) @(posedge clk);
    #1;
    check("R1 all beats delivered", 8'(exq.size()), 8'h00);
    finish_run();
  end
endmodule